// File: doc/BRIEF.md
# Cluster Power-Domain Orderer

This block turns a single cluster-level power request into an ordered series of per-domain requests for a shared rail sequencer. A cluster holds one shared cache domain and a parameterised number of core domains; a functional-mask input says which cores are present. The orderer chooses the visiting order from the direction of the request, applies the rail limits that differ between the cache and the cores, and waits for the sequencer's completion after every domain it hands out.

The rail sequencer is external. The orderer gives it a one-cycle `seq_start` together with a domain (cache or a core index), a direction and a rail code, and then waits for `seq_done`. The sequencer reports a failure by raising `seq_err` in the same cycle as `seq_done`. A request may cover the whole cluster or only one half of it. A half contains a fixed group of cores and never includes the cache.

When the walk is over, the orderer pulses `done`. It also leaves three result flags standing for the caller: an error, a rail-downgrade warning and a "no functional core" notice.

Top module: `clu_pwr_orderer`

## Requirements
- R1: For a full-cluster power-on (`req_on`=1, `req_half`=0), the cache domain is handed out first. Every functional core follows, in ascending index order.
- R2: For a full-cluster power-off (`req_on`=0, `req_half`=0), every functional core is handed out in ascending index order. The cache domain is handed out last.
- R3: A core whose `core_mask` bit is 0 gets no handshake at all.
- R4: When no functional core is in scope, `no_core` is 1 at `done`. On a full power-off the cache is then not handed out. On a full power-on the cache is still handed out.
- R5: Rail codes are 2'b01 logic, 2'b10 array and 2'b11 both. The cache receives the requested code unchanged. A core given a request that includes the array rail (2'b11) is handed out with 2'b01 only, and `warn` is set.
- R6: A core given an array-only request (2'b10) gets no handshake, and `warn` is set.
- R7: When `req_half`=1, only the functional cores with index/CORES_PER_HALF equal to `req_half_sel` are handed out (cores 2s and 2s+1 with the defaults). The cache is never handed out, and `no_core` reports when none of those cores is functional.
- R8: When `seq_err` comes back with `seq_done`, no further domain is handed out. `done` then follows with `err`=1.
- R9: `done` is a one-cycle pulse. `err`, `warn` and `no_core` hold their values until the next accepted start. A `req_start` that arrives while `busy` is ignored.
- R10: Every handshake carries the requested direction on `seq_on`. A rail code of 2'b00 causes no handshake for any domain, and the request still completes with `done`.
- R11: After reset, `busy`, `done`, `seq_start`, `err`, `warn` and `no_core` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_start | input | 1 | Start pulse for a cluster request; only accepted when idle |
| req_on | input | 1 | Direction: 1 power on, 0 power off |
| req_rail | input | 2 | Rail code: 01 logic, 10 array, 11 both, 00 none |
| req_half | input | 1 | 1 restricts the request to one half of the cores |
| req_half_sel | input | SEL_W | Selects the half when `req_half` is 1 |
| core_mask | input | NUM_CORES | 1 marks a functional core |
| seq_start | output | 1 | One-cycle request to the rail sequencer |
| seq_cache | output | 1 | 1 when the handed-out domain is the cache |
| seq_core | output | IDX_W | Core index of the handed-out domain |
| seq_on | output | 1 | Direction for the sequencer |
| seq_rail | output | 2 | Effective rail code for the sequencer |
| seq_done | input | 1 | Sequencer completion |
| seq_err | input | 1 | Sequencer failure, qualified by `seq_done` |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | The last request was aborted by a sequencer error |
| warn | output | 1 | A core's rail request was downgraded or refused |
| no_core | output | 1 | No functional core was in scope |

## Verification
Some properties are checked on every cycle. Every core handed out is functional and in scope, and it carries the logic rail only. The cache is never handed out in half mode. No handshake follows a reported error. A handshake never carries the empty rail code. `seq_start` and `done` are single pulses, and the flags stay still while idle.

Other behaviour needs whole scenarios in the bench. That covers the order of domains for each direction, skipping the cache when no core is present, the point at which an error cuts the walk short, and ignoring a start while busy. The bench's sequencer model records every handshake and compares the list with the expected one.

// File: rtl/clu_pwr_pkg.sv
package clu_pwr_pkg;

   typedef enum logic [1:0] {
      RAIL_NONE  = 2'b00,
      RAIL_LOGIC = 2'b01,
      RAIL_ARRAY = 2'b10,
      RAIL_BOTH  = 2'b11
   } rail_t;

   typedef enum logic [1:0] {
      PH_CACHE_FIRST = 2'd0,
      PH_CORES       = 2'd1,
      PH_CACHE_LAST  = 2'd2,
      PH_END         = 2'd3
   } phase_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_NEXT = 2'd1,
      ST_WAIT = 2'd2
   } ord_state_t;

endpackage

// File: rtl/clu_scope_mask.sv
module clu_scope_mask #(
   parameter int NUM_CORES      = 4,
   parameter int CORES_PER_HALF = 2,
   parameter int SEL_W          = 1
) (
   input  logic                 half_en,
   input  logic [SEL_W-1:0]     half_sel,
   input  logic [NUM_CORES-1:0] core_mask,
   output logic [NUM_CORES-1:0] scope_mask
);
   localparam int NUM_HALVES = NUM_CORES / CORES_PER_HALF;

   for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
      if (NUM_HALVES > 1) begin : g_split
         localparam logic [SEL_W-1:0] MY_HALF = SEL_W'(i / CORES_PER_HALF);
         assign scope_mask[i] = core_mask[i] & (~half_en | (half_sel == MY_HALF));
      end else begin : g_single
         assign scope_mask[i] = core_mask[i] & (~half_en | (half_sel == '0));
      end
   end
endmodule

// File: rtl/clu_core_scan.sv
module clu_core_scan #(
   parameter int NUM_CORES = 4,
   parameter int IDX_W     = 2,
   parameter int PTR_W     = 3
) (
   input  logic [NUM_CORES-1:0] mask,
   input  logic [PTR_W-1:0]     from_ptr,
   output logic                 found,
   output logic [IDX_W-1:0]     idx
);
   // lowest set mask bit at or above from_ptr
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = NUM_CORES - 1; i >= 0; i--) begin
         if (mask[i] && (PTR_W'(i) >= from_ptr)) begin
            found = 1'b1;
            idx   = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/clu_rail_policy.sv
module clu_rail_policy #(
   parameter bit IS_CORE = 1'b0
) (
   input  logic [1:0] req_rail,
   output logic [1:0] eff_rail,
   output logic       warn
);
   import clu_pwr_pkg::*;

   if (IS_CORE) begin : g_core
      // cores carry the logic rail only; any array ask is flagged
      assign eff_rail = req_rail[0] ? RAIL_LOGIC : RAIL_NONE;
      assign warn     = req_rail[1];
   end else begin : g_cache
      assign eff_rail = req_rail;
      assign warn     = 1'b0;
   end
endmodule

// File: rtl/clu_pwr_orderer.sv
module clu_pwr_orderer #(
   parameter int NUM_CORES      = 4,
   parameter int CORES_PER_HALF = 2,
   localparam int NUM_HALVES    = NUM_CORES / CORES_PER_HALF,
   localparam int IDX_W         = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
   localparam int PTR_W         = $clog2(NUM_CORES + 1),
   localparam int SEL_W         = (NUM_HALVES > 1) ? $clog2(NUM_HALVES) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_start,
   input  logic                 req_on,
   input  logic [1:0]           req_rail,
   input  logic                 req_half,
   input  logic [SEL_W-1:0]     req_half_sel,
   input  logic [NUM_CORES-1:0] core_mask,
   output logic                 seq_start,
   output logic                 seq_cache,
   output logic [IDX_W-1:0]     seq_core,
   output logic                 seq_on,
   output logic [1:0]           seq_rail,
   input  logic                 seq_done,
   input  logic                 seq_err,
   output logic                 busy,
   output logic                 done,
   output logic                 err,
   output logic                 warn,
   output logic                 no_core
);
   import clu_pwr_pkg::*;

   if (NUM_CORES < 1) begin : g_chk_cores
      $error("NUM_CORES must be at least 1");
   end
   if (CORES_PER_HALF < 1 || (NUM_CORES % CORES_PER_HALF) != 0) begin : g_chk_half
      $error("NUM_CORES must be a multiple of CORES_PER_HALF");
   end

   ord_state_t             st_q;
   phase_t                 phase_q;
   logic                   on_q, half_q, any_core_q;
   logic [1:0]             rail_q;
   logic [NUM_CORES-1:0]   scope_q;
   logic [PTR_W-1:0]       ptr_q;

   logic [NUM_CORES-1:0]   scope_now;
   logic                   scan_found;
   logic [IDX_W-1:0]       scan_idx;
   logic [1:0]             cache_rail, core_rail;
   logic                   cache_warn, core_warn;

   clu_scope_mask #(
      .NUM_CORES(NUM_CORES), .CORES_PER_HALF(CORES_PER_HALF), .SEL_W(SEL_W)
   ) u_scope (
      .half_en(req_half), .half_sel(req_half_sel),
      .core_mask(core_mask), .scope_mask(scope_now)
   );

   clu_core_scan #(.NUM_CORES(NUM_CORES), .IDX_W(IDX_W), .PTR_W(PTR_W)) u_scan (
      .mask(scope_q), .from_ptr(ptr_q), .found(scan_found), .idx(scan_idx)
   );

   clu_rail_policy #(.IS_CORE(1'b0)) u_cache_pol (
      .req_rail(rail_q), .eff_rail(cache_rail), .warn(cache_warn)
   );
   clu_rail_policy #(.IS_CORE(1'b1)) u_core_pol (
      .req_rail(rail_q), .eff_rail(core_rail), .warn(core_warn)
   );

   assign busy   = (st_q != ST_IDLE);
   assign seq_on = on_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         phase_q    <= PH_END;
         on_q       <= 1'b0;
         half_q     <= 1'b0;
         any_core_q <= 1'b0;
         rail_q     <= RAIL_NONE;
         scope_q    <= '0;
         ptr_q      <= '0;
         seq_start  <= 1'b0;
         seq_cache  <= 1'b0;
         seq_core   <= '0;
         seq_rail   <= RAIL_NONE;
         done       <= 1'b0;
         err        <= 1'b0;
         warn       <= 1'b0;
         no_core    <= 1'b0;
      end else begin
         seq_start <= 1'b0;
         done      <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (req_start) begin
                  on_q       <= req_on;
                  half_q     <= req_half;
                  rail_q     <= req_rail;
                  scope_q    <= scope_now;
                  ptr_q      <= '0;
                  any_core_q <= 1'b0;
                  err        <= 1'b0;
                  warn       <= 1'b0 | cache_warn;
                  no_core    <= 1'b0;
                  phase_q    <= (req_on && !req_half) ? PH_CACHE_FIRST : PH_CORES;
                  st_q       <= ST_NEXT;
               end
            end
            ST_NEXT: begin
               unique case (phase_q)
                  PH_CACHE_FIRST: begin
                     phase_q <= PH_CORES;
                     if (cache_rail != RAIL_NONE) begin
                        seq_start <= 1'b1;
                        seq_cache <= 1'b1;
                        seq_rail  <= cache_rail;
                        st_q      <= ST_WAIT;
                     end
                  end
                  PH_CORES: begin
                     if (scan_found) begin
                        any_core_q <= 1'b1;
                        ptr_q      <= PTR_W'(scan_idx) + PTR_W'(1);
                        if (core_warn) warn <= 1'b1;
                        if (core_rail != RAIL_NONE) begin
                           seq_start <= 1'b1;
                           seq_cache <= 1'b0;
                           seq_core  <= scan_idx;
                           seq_rail  <= core_rail;
                           st_q      <= ST_WAIT;
                        end
                     end else begin
                        phase_q <= (!on_q && !half_q) ? PH_CACHE_LAST : PH_END;
                     end
                  end
                  PH_CACHE_LAST: begin
                     phase_q <= PH_END;
                     if (any_core_q && cache_rail != RAIL_NONE) begin
                        seq_start <= 1'b1;
                        seq_cache <= 1'b1;
                        seq_rail  <= cache_rail;
                        st_q      <= ST_WAIT;
                     end
                  end
                  default: begin
                     done    <= 1'b1;
                     no_core <= ~any_core_q;
                     st_q    <= ST_IDLE;
                  end
               endcase
            end
            ST_WAIT: begin
               if (seq_done) begin
                  if (seq_err) begin
                     err     <= 1'b1;
                     phase_q <= PH_END;
                  end
                  st_q <= ST_NEXT;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // ---------------- assertions ----------------
   assert_start_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      seq_start |=> !seq_start);

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_flags_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !req_start) |=> ($stable(warn) && $stable(err) && $stable(no_core)));

   assert_no_start_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      seq_start |-> busy);

   assert_core_logic_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_start && !seq_cache) |-> (seq_rail == 2'b01));

   assert_core_functional_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_start && !seq_cache) |-> scope_q[seq_core]);

   assert_half_no_cache_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_start && half_q) |-> !seq_cache);

   assert_stop_after_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
      seq_start |-> !err);

   assert_rail_nonempty_R10: assert property (@(posedge clk) disable iff (!rst_n)
      seq_start |-> (seq_rail != 2'b00));

endmodule

// File: tb/clu_pwr_orderer_bench.sv
module clu_pwr_orderer_bench;
   localparam int NC = 4;
   localparam int VW = 44;
   localparam int NV = 13;

   // {on, rail, half, sel, mask, err_at, n_exp, seq(6 nibbles, first lowest; F = cache), warn, no_core, err}
   localparam logic [VW-1:0] VEC [NV] = '{
      {1'b1, 2'b11, 1'b0, 1'b0, 4'b1111, 4'hF, 4'd5, 24'h03210F, 1'b1, 1'b0, 1'b0},
      {1'b0, 2'b11, 1'b0, 1'b0, 4'b1111, 4'hF, 4'd5, 24'h0F3210, 1'b1, 1'b0, 1'b0},
      {1'b1, 2'b01, 1'b0, 1'b0, 4'b1010, 4'hF, 4'd3, 24'h00031F, 1'b0, 1'b0, 1'b0},
      {1'b0, 2'b01, 1'b0, 1'b0, 4'b0101, 4'hF, 4'd3, 24'h000F20, 1'b0, 1'b0, 1'b0},
      {1'b0, 2'b11, 1'b0, 1'b0, 4'b0000, 4'hF, 4'd0, 24'h000000, 1'b0, 1'b1, 1'b0},
      {1'b1, 2'b10, 1'b0, 1'b0, 4'b1111, 4'hF, 4'd1, 24'h00000F, 1'b1, 1'b0, 1'b0},
      {1'b0, 2'b10, 1'b0, 1'b0, 4'b0011, 4'hF, 4'd1, 24'h00000F, 1'b1, 1'b0, 1'b0},
      {1'b1, 2'b11, 1'b1, 1'b1, 4'b1111, 4'hF, 4'd2, 24'h000032, 1'b1, 1'b0, 1'b0},
      {1'b0, 2'b01, 1'b1, 1'b0, 4'b1100, 4'hF, 4'd0, 24'h000000, 1'b0, 1'b1, 1'b0},
      {1'b1, 2'b11, 1'b0, 1'b0, 4'b1111, 4'h1, 4'd2, 24'h00000F, 1'b1, 1'b0, 1'b1},
      {1'b0, 2'b01, 1'b0, 1'b0, 4'b1111, 4'h4, 4'd5, 24'h0F3210, 1'b0, 1'b0, 1'b1},
      {1'b1, 2'b00, 1'b0, 1'b0, 4'b1111, 4'hF, 4'd0, 24'h000000, 1'b0, 1'b0, 1'b0},
      {1'b1, 2'b01, 1'b0, 1'b0, 4'b0000, 4'hF, 4'd1, 24'h00000F, 1'b0, 1'b1, 1'b0}
   };
   localparam string TAG [NV] = '{"R1_R5", "R2_R5", "R1_R3", "R2_R3", "R4",
                                  "R6", "R6", "R7", "R7", "R8", "R8", "R10", "R4"};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_start = 1'b0, req_on = 1'b0, req_half = 1'b0;
   logic [1:0] req_rail = 2'b00;
   logic [0:0] req_half_sel = 1'b0;
   logic [NC-1:0] core_mask = '0;
   logic seq_start, seq_cache, seq_on;
   logic [1:0] seq_core, seq_rail;
   logic seq_done = 1'b0, seq_err = 1'b0;
   logic busy, done, err, warn, no_core;

   int n_chk = 0, n_err = 0;
   int log_n = 0;
   int err_at = 15;
   int base_n = 0;
   logic       lg_cache [64];
   logic [1:0] lg_core  [64];
   logic       lg_on    [64];
   logic [1:0] lg_rail  [64];

   always #4 clk = ~clk;   // 125 MHz

   clu_pwr_orderer #(.NUM_CORES(NC), .CORES_PER_HALF(2)) u_clu_pwr_orderer (
      .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_on(req_on),
      .req_rail(req_rail), .req_half(req_half), .req_half_sel(req_half_sel),
      .core_mask(core_mask), .seq_start(seq_start), .seq_cache(seq_cache),
      .seq_core(seq_core), .seq_on(seq_on), .seq_rail(seq_rail),
      .seq_done(seq_done), .seq_err(seq_err), .busy(busy), .done(done),
      .err(err), .warn(warn), .no_core(no_core)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // sequencer model
   initial begin
      forever begin
         @(negedge clk);
         if (seq_start === 1'b1) begin
            lg_cache[log_n & 63] = seq_cache;
            lg_core[log_n & 63]  = seq_core;
            lg_on[log_n & 63]    = seq_on;
            lg_rail[log_n & 63]  = seq_rail;
            log_n++;
            repeat (2) @(negedge clk);
            seq_done = 1'b1;
            seq_err  = ((log_n - 1 - base_n) == err_at);
            @(negedge clk);
            seq_done = 1'b0;
            seq_err  = 1'b0;
         end
      end
   end

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   task automatic start_req(input logic on, input logic [1:0] rail, input logic half,
                            input logic sel, input logic [NC-1:0] mask);
      @(negedge clk);
      req_on = on; req_rail = rail; req_half = half; req_half_sel = sel; core_mask = mask;
      req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
   endtask

   task automatic wait_done(input string tag);
      int t = 0;
      while (done !== 1'b1 && t < 2000) begin
         @(negedge clk);
         t++;
      end
      chk({tag, " done seen"}, int'(done === 1'b1), 1);
   endtask

   task automatic check_log(input string tag, input logic on, input logic [1:0] rail,
                            input int n_exp, input logic [23:0] seq);
      chk({tag, " handshake count"}, log_n - base_n, n_exp);
      for (int i = 0; i < n_exp && i < (log_n - base_n); i++) begin
         logic [3:0] d;
         d = seq[i*4 +: 4];
         chk({tag, " seq_on"}, int'(lg_on[(base_n + i) & 63]), int'(on));
         if (d == 4'hF) begin
            chk({tag, " cache order"}, int'(lg_cache[(base_n + i) & 63]), 1);
            chk({tag, " cache rail"}, int'(lg_rail[(base_n + i) & 63]), int'(rail));
         end else begin
            chk({tag, " core order"}, int'(lg_cache[(base_n + i) & 63]), 0);
            chk({tag, " core index"}, int'(lg_core[(base_n + i) & 63]), int'(d));
            chk({tag, " core rail"}, int'(lg_rail[(base_n + i) & 63]), 1);
         end
      end
   endtask

   initial begin
      // R11: reset state
      repeat (3) @(negedge clk);
      chk("R11 busy", int'(busy), 0);
      chk("R11 done", int'(done), 0);
      chk("R11 seq_start", int'(seq_start), 0);
      chk("R11 flags", int'({err, warn, no_core}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int k = 0; k < NV; k++) begin
         logic [VW-1:0] v;
         v = VEC[k];
         base_n = log_n;
         err_at = int'(v[34:31]);
         start_req(v[43], v[42:41], v[40], v[39], v[38:35]);
         wait_done(TAG[k]);
         @(negedge clk);
         chk({TAG[k], " R9 done one cycle"}, int'(done), 0);
         chk({TAG[k], " warn"}, int'(warn), int'(v[2]));
         chk({TAG[k], " no_core"}, int'(no_core), int'(v[1]));
         chk({TAG[k], " err"}, int'(err), int'(v[0]));
         check_log(TAG[k], v[43], v[42:41], int'(v[30:27]), v[26:3]);
         repeat (3) @(negedge clk);
      end

      // R9: flags held while idle, new start clears them
      base_n = log_n;
      err_at = 15;
      start_req(1'b1, 2'b11, 1'b0, 1'b0, 4'b0001);
      wait_done("R9 hold");
      repeat (10) @(negedge clk);
      chk("R9 warn held", int'(warn), 1);
      chk("R9 done quiet", int'(done), 0);
      base_n = log_n;
      start_req(1'b1, 2'b01, 1'b0, 1'b0, 4'b0001);
      chk("R9 warn cleared on start", int'(warn), 0);
      wait_done("R9 clear");
      @(negedge clk);
      chk("R9 warn after logic run", int'(warn), 0);

      // R9: start while busy is ignored
      repeat (3) @(negedge clk);
      base_n = log_n;
      start_req(1'b1, 2'b11, 1'b0, 1'b0, 4'b1111);
      while (log_n == base_n) @(negedge clk);
      start_req(1'b0, 2'b01, 1'b1, 1'b1, 4'b0001);
      wait_done("R9 busy");
      @(negedge clk);
      check_log("R9 busy ignore", 1'b1, 2'b11, 5, 24'h03210F);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule